// File: doc/BRIEF.md
# Byte-Stream to Word-Program Packer

This block sits in front of a flash programmer that can only program whole, aligned 32-bit words. A client posts a write request with a starting byte address and a byte count. It then streams the payload bytes over a valid/ready channel. The packer groups the bytes into aligned words and hands each word to the downstream programmer. It waits for that word's completion before it accepts further bytes.

Flash programming can only clear bits. For this reason, byte lanes that the request does not cover are filled with 0xFF rather than merged with existing contents, so those bytes stay in their erased state. This applies to the lanes below an unaligned start and the lanes past the last byte. When the request finishes, the block pulses a done flag. It also presents an error flag and the number of payload bytes that belong to successfully programmed words. The first programming failure ends the request.

Top module: `flash_word_packer`

## Requirements
- R1: After reset the block is idle: req_ready_o=1, byte_ready_o=0, prog_valid_o=0, done_o=0, err_o=0, count_o=0.
- R2: Word addresses are the start address with its low 2 bits cleared, then increase by 4 for each following word.
- R3: In the first word of an unaligned request, every byte lane below the start offset (start address bits 1:0) carries 0xFF.
- R4: Payload bytes are packed little-endian in stream order: byte lane k occupies word bits 8k+7:8k, and the byte for address A goes to lane A mod 4.
- R5: In the last word, every lane past the final payload byte carries 0xFF.
- R6: Each word that the request fully covers carries its four payload bytes unmodified.
- R7: A request with a byte count of zero issues no word and raises done_o in the cycle after acceptance, with count_o=0 and err_o=0.
- R8: byte_ready_o stays low from the moment a word is complete until the programmer reports completion of that word.
- R9: While prog_valid_o is high and prog_ready_i is low, prog_valid_o, prog_addr_o and prog_data_o hold steady.
- R10: If prog_err_i is high with prog_done_i, the request ends with err_o=1. No further word is issued, and count_o equals the payload bytes of the words completed before the failure.
- R11: A request that succeeds ends with a one-cycle done_o pulse, err_o=0 and count_o equal to the byte count. err_o and count_o hold until the next request is accepted.
- R12: A request that starts and ends inside one word produces a single word with 0xFF on both sides of the payload lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Packer idle, request taken on valid |
| req_addr_i | input | ADDR_W | Starting byte address |
| req_len_i | input | LEN_W | Byte count |
| byte_valid_i | input | 1 | Payload byte present |
| byte_ready_o | output | 1 | Payload byte accepted on valid |
| byte_data_i | input | 8 | Payload byte |
| prog_valid_o | output | 1 | Word program request |
| prog_ready_i | input | 1 | Programmer takes the word |
| prog_addr_o | output | ADDR_W | Aligned word byte address |
| prog_data_o | output | 8*BYTES | Packed word |
| prog_done_i | input | 1 | Word program finished |
| prog_err_i | input | 1 | Word program failed, valid with prog_done_i |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Last request ended in failure |
| count_o | output | LEN_W | Bytes of completed words in last request |

## Verification
The packer is tried with an aligned multi-word request, which shows that full words pass through untouched. It is also tried with a request that is unaligned at both ends, which separates leading padding from trailing padding, and with a short request inside one word, where both paddings meet. A zero-length request confirms that nothing reaches the programmer. A failure injected on a middle word distinguishes a count of completed bytes from a count of accepted bytes. Stalling prog_ready_i and delaying completion exposes any leak of the held word or of the byte backpressure.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } fwp_state_e;
endpackage

// File: rtl/fwp_word_asm.sv
module fwp_word_asm #(
  parameter int BYTES = 4,
  localparam int LANE_W = $clog2(BYTES),
  localparam int DATA_W = 8 * BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [7:0]        byte_i,
  output logic [DATA_W-1:0] word_o
);
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                lane_q <= 8'hFF;
      else if (clear_i)                           lane_q <= 8'hFF;
      else if (wr_i && lane_i == LANE_W'(g))      lane_q <= byte_i;
    end
    assign word_o[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/fwp_ctrl.sv
module fwp_ctrl
  import fwp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int BYTES  = 4,
  localparam int LANE_W = $clog2(BYTES),
  localparam int FILL_W = LANE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic              prog_valid_o,
  input  logic              prog_ready_i,
  output logic [ADDR_W-1:0] prog_addr_o,
  input  logic              prog_done_i,
  input  logic              prog_err_i,
  output logic              done_o,
  output logic              err_o,
  output logic [LEN_W-1:0]  count_o,
  output logic              asm_clear_o,
  output logic              asm_wr_o,
  output logic [LANE_W-1:0] asm_lane_o
);
  fwp_state_e        state_q, state_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [LEN_W-1:0]  count_q, count_d;
  logic              err_q, err_d;
  logic              req_hs, byte_hs;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign byte_ready_o = (state_q == ST_FILL);
  assign prog_valid_o = (state_q == ST_ISSUE);
  assign done_o       = (state_q == ST_DONE);
  assign prog_addr_o  = waddr_q;
  assign err_o        = err_q;
  assign count_o      = count_q;
  assign asm_lane_o   = lane_q;
  assign req_hs       = req_valid_i && req_ready_o;
  assign byte_hs      = byte_valid_i && byte_ready_o;
  assign asm_wr_o     = byte_hs;

  always_comb begin
    state_d     = state_q;
    waddr_d     = waddr_q;
    lane_d      = lane_q;
    remain_d    = remain_q;
    fill_d      = fill_q;
    count_d     = count_q;
    err_d       = err_q;
    asm_clear_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_hs) begin
        waddr_d     = {req_addr_i[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
        lane_d      = req_addr_i[LANE_W-1:0];
        remain_d    = req_len_i;
        fill_d      = '0;
        count_d     = '0;
        err_d       = 1'b0;
        asm_clear_o = 1'b1;
        state_d     = (req_len_i == '0) ? ST_DONE : ST_FILL;
      end
      ST_FILL: if (byte_hs) begin
        lane_d   = lane_q + LANE_W'(1);
        remain_d = remain_q - LEN_W'(1);
        fill_d   = fill_q + FILL_W'(1);
        if (lane_q == LANE_W'(BYTES - 1) || remain_q == LEN_W'(1)) state_d = ST_ISSUE;
      end
      ST_ISSUE: if (prog_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (prog_done_i) begin
        if (prog_err_i) begin
          err_d   = 1'b1;
          state_d = ST_DONE;
        end else begin
          count_d = count_q + LEN_W'(fill_q);
          fill_d  = '0;
          if (remain_q == '0) begin
            state_d = ST_DONE;
          end else begin
            waddr_d     = waddr_q + ADDR_W'(BYTES);
            lane_d      = '0;
            asm_clear_o = 1'b1;
            state_d     = ST_FILL;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      waddr_q  <= '0;
      lane_q   <= '0;
      remain_q <= '0;
      fill_q   <= '0;
      count_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      waddr_q  <= waddr_d;
      lane_q   <= lane_d;
      remain_q <= remain_d;
      fill_q   <= fill_d;
      count_q  <= count_d;
      err_q    <= err_d;
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_valid_o |-> prog_addr_o[LANE_W-1:0] == '0); // R2
  AST_ZERO_LEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_hs && req_len_i == '0) |=> (done_o && !prog_valid_o)); // R7
  AST_NO_BYTE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_valid_o |-> !byte_ready_o); // R8
  AST_HOLD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_valid_o && !prog_ready_i) |=> (prog_valid_o && $stable(prog_addr_o))); // R9
  AST_NO_ISSUE_AFTER_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !req_hs) |=> !prog_valid_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
endmodule

// File: rtl/flash_word_packer.sv
module flash_word_packer #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int BYTES  = 4,
  localparam int LANE_W = $clog2(BYTES),
  localparam int DATA_W = 8 * BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic [7:0]        byte_data_i,
  output logic              prog_valid_o,
  input  logic              prog_ready_i,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  input  logic              prog_done_i,
  input  logic              prog_err_i,
  output logic              done_o,
  output logic              err_o,
  output logic [LEN_W-1:0]  count_o
);
  logic              asm_clear, asm_wr;
  logic [LANE_W-1:0] asm_lane;

  fwp_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTES(BYTES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_addr_i   (req_addr_i),
    .req_len_i    (req_len_i),
    .byte_valid_i (byte_valid_i),
    .byte_ready_o (byte_ready_o),
    .prog_valid_o (prog_valid_o),
    .prog_ready_i (prog_ready_i),
    .prog_addr_o  (prog_addr_o),
    .prog_done_i  (prog_done_i),
    .prog_err_i   (prog_err_i),
    .done_o       (done_o),
    .err_o        (err_o),
    .count_o      (count_o),
    .asm_clear_o  (asm_clear),
    .asm_wr_o     (asm_wr),
    .asm_lane_o   (asm_lane)
  );

  fwp_word_asm #(.BYTES(BYTES)) u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (asm_clear),
    .wr_i    (asm_wr),
    .lane_i  (asm_lane),
    .byte_i  (byte_data_i),
    .word_o  (prog_data_o)
  );

  AST_HOLD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_valid_o && !prog_ready_i) |=> $stable(prog_data_o)); // R9
  AST_WORD_NOT_ERASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_valid_o) |-> $past(byte_ready_o && byte_valid_i)); // R8
endmodule

// File: tb/tb_flash_word_packer.sv
module tb_flash_word_packer;
  localparam int ADDR_W = 24;
  localparam int LEN_W  = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [LEN_W-1:0]  req_len_i = '0;
  logic              byte_valid_i = 1'b0;
  logic              byte_ready_o;
  logic [7:0]        byte_data_i = '0;
  logic              prog_valid_o;
  logic              prog_ready_i = 1'b0;
  logic [ADDR_W-1:0] prog_addr_o;
  logic [31:0]       prog_data_o;
  logic              prog_done_i = 1'b0;
  logic              prog_err_i = 1'b0;
  logic              done_o;
  logic              err_o;
  logic [LEN_W-1:0]  count_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  flash_word_packer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTES(4)) dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + i * 37 + (i >> 3));
  endfunction

  function automatic int nwords(input int addr, input int len);
    return ((addr + len - 1) >> 2) - (addr >> 2) + 1;
  endfunction

  function automatic logic [31:0] exp_word(input int addr, input int len, input int seed, input int j);
    logic [31:0] w;
    int base = (addr & ~3) + 4 * j;
    for (int l = 0; l < 4; l++) begin
      int a = base + l;
      w[8*l +: 8] = (a >= addr && a < addr + len) ? pat(seed, a - addr) : 8'hFF;
    end
    return w;
  endfunction

  function automatic int bytes_in(input int addr, input int len, input int j);
    int n = 0;
    int base = (addr & ~3) + 4 * j;
    for (int l = 0; l < 4; l++)
      if (base + l >= addr && base + l < addr + len) n++;
    return n;
  endfunction

  task automatic feeder(input int nb, input int seed);
    for (int i = 0; i < nb; i++) begin
      byte_valid_i = 1'b1;
      byte_data_i  = pat(seed, i);
      forever begin
        if (byte_ready_o) begin
          @(negedge clk_i);
          break;
        end
        @(negedge clk_i);
      end
    end
    byte_valid_i = 1'b0;
  endtask

  task automatic responder(input int addr, input int len, input int seed,
                           input int fail_at, input int stall, input string rq);
    int nw = (len == 0) ? 0 : nwords(addr, len);
    for (int j = 0; j < nw; j++) begin
      logic [31:0] d0;
      logic [ADDR_W-1:0] a0;
      while (!prog_valid_o) @(negedge clk_i);
      a0 = prog_addr_o;
      d0 = prog_data_o;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk_i);
        check(prog_valid_o && prog_data_o == d0 && prog_addr_o == a0, "R9 hold",
              {prog_valid_o, prog_data_o}, {1'b1, d0});
      end
      prog_ready_i = 1'b1;
      @(negedge clk_i);
      prog_ready_i = 1'b0;
      check(a0 == ADDR_W'((addr & ~3) + 4 * j), {rq, " R2 addr"}, a0, (addr & ~3) + 4 * j);
      check(d0 == exp_word(addr, len, seed, j), {rq, " data"}, d0, exp_word(addr, len, seed, j));
      for (int k = 0; k < 2; k++) begin
        check(!byte_ready_o, "R8 backpressure", byte_ready_o, 0);
        @(negedge clk_i);
      end
      prog_done_i = 1'b1;
      prog_err_i  = (j == fail_at);
      @(negedge clk_i);
      prog_done_i = 1'b0;
      prog_err_i  = 1'b0;
      if (j == fail_at) break;
    end
  endtask

  task automatic run_req(input int addr, input int len, input int seed,
                         input int fail_at, input int stall, input string rq);
    int nb = 0;
    int exp_cnt = 0;
    int nw = (len == 0) ? 0 : nwords(addr, len);
    bit fails = (fail_at >= 0 && fail_at < nw);
    for (int j = 0; j < nw; j++) begin
      if (!fails || j <= fail_at) nb += bytes_in(addr, len, j);
      if (!fails || j < fail_at) exp_cnt += bytes_in(addr, len, j);
    end
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1;
    req_addr_i  = ADDR_W'(addr);
    req_len_i   = LEN_W'(len);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    fork
      feeder(nb, seed);
      responder(addr, len, seed, fail_at, stall, rq);
    join
    while (!done_o) @(negedge clk_i);
    check(err_o == fails, {rq, fails ? " R10 err" : " R11 err"}, err_o, fails);
    check(count_o == LEN_W'(exp_cnt), {rq, fails ? " R10 count" : " R11 count"}, count_o, exp_cnt);
    check(!prog_valid_o, {rq, " no word at done"}, prog_valid_o, 0);
    @(negedge clk_i);
    check(!done_o && err_o == fails && count_o == LEN_W'(exp_cnt), "R11 pulse/hold",
          {done_o, err_o, count_o}, {1'b0, fails, LEN_W'(exp_cnt)});
    check(!prog_valid_o, "R10 no later word", prog_valid_o, 0);
  endtask

  task automatic t_reset;
    check(req_ready_o && !byte_ready_o && !prog_valid_o && !done_o && !err_o && count_o == 0,
          "R1 reset", {req_ready_o, byte_ready_o, prog_valid_o, done_o, err_o, count_o},
          {1'b1, 5'b0, LEN_W'(0)});
  endtask

  task automatic t_aligned;     run_req(32'h100, 12, 3, -1, 0, "R6 R4 aligned"); endtask
  task automatic t_unaligned;   run_req(32'h203, 7, 91, -1, 1, "R3 R5 unaligned"); endtask
  task automatic t_inner;       run_req(32'h011, 2, 200, -1, 0, "R12 inner"); endtask
  task automatic t_zero;        run_req(32'h040, 0, 5, -1, 0, "R7 zero"); endtask
  task automatic t_fail;        run_req(32'h302, 10, 17, 1, 0, "R10 fail"); endtask
  task automatic t_stall;       run_req(32'h401, 9, 66, -1, 3, "R9 stall"); endtask
  task automatic t_fail_first;  run_req(32'h501, 5, 44, 0, 2, "R10 first"); endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_aligned();
    t_unaligned();
    t_inner();
    t_zero();
    t_fail();
    t_aligned();
    t_stall();
    t_fail_first();
    run_req(32'h602, 3, 123, -1, 0, "R3 R5 tail");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    while (cyc < 20000 && !finished) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule